// File: doc/BRIEF.md
# Flash Block Map and Boot Lock Decoder

This block sits beside the command controller of a 1M-word by 16-bit flash array. It takes a 20-bit word address and reports which erase block that address falls in. It also reports whether the block is one of the small 4K-word blocks, and whether it is one of the two boot blocks. A further output tells the controller whether a program or erase aimed at that address may go ahead.

The array holds thirty-one 32K-word blocks and eight 4K-word blocks. A static strap chooses where the eight small blocks sit. With the strap high they occupy the highest 32K words of the address space. With the strap low they occupy the lowest 32K words. In both layouts the two small blocks at the outer end of the address space are the boot blocks. A lock-release pin gates writes to the boot blocks only.

The decode is purely combinational. The address, strap and lock-release inputs are plain control pins, and every output follows them in the same cycle. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `flash_block_map`

## Requirements
- R1: With `top_boot_i`=1 and an address in F8000h–FFFFFh, `small_blk_o`=1 and `blk_idx_o` = 31 + address bits [14:12].
- R2: With `top_boot_i`=1 and an address in 00000h–F7FFFh, `small_blk_o`=0 and `blk_idx_o` = address bits [19:15], which gives 0 to 30.
- R3: With `top_boot_i`=0 and an address in 00000h–07FFFh, `small_blk_o`=1 and `blk_idx_o` = address bits [14:12], which gives 0 to 7.
- R4: With `top_boot_i`=0 and an address in 08000h–FFFFFh, `small_blk_o`=0 and `blk_idx_o` = address bits [19:15] + 7, which gives 8 to 38.
- R5: `boot_blk_o`=1 exactly for indices 37 and 38 (FE000h–FFFFFh) when `top_boot_i`=1, and for indices 0 and 1 (00000h–01FFFh) when `top_boot_i`=0. A boot block is always a small block.
- R6: `write_ok_o`=0 when `boot_blk_o`=1 and `boot_unlock_i`=0. `write_ok_o`=1 when `boot_blk_o`=1 and `boot_unlock_i`=1.
- R7: For any address outside the boot blocks, `write_ok_o`=1 whatever the value of `boot_unlock_i`. `boot_unlock_i` never changes `blk_idx_o`, `small_blk_o` or `boot_blk_o`.
- R8: Every word from the first to the last of a block's range gives the same `blk_idx_o`. Indices stay within 0 to 38 and rise with the address in both layouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Word address to classify |
| top_boot_i | input | 1 | Layout strap: 1 puts the small blocks at the top, 0 at the bottom |
| boot_unlock_i | input | 1 | 1 allows program/erase of the boot blocks |
| blk_idx_o | output | 6 | Block index, counting 0 to 38 from the lowest address |
| small_blk_o | output | 1 | Address lies in a 4K-word block |
| boot_blk_o | output | 1 | Address lies in one of the two boot blocks |
| write_ok_o | output | 1 | A program or erase at this address is permitted |

## Verification
The immediate assertions assume that every input carries a known 0 or 1 and that the outputs have settled from the current inputs when they are evaluated. The bench drives only defined values. It changes the inputs just after a rising clock edge and compares the outputs at the next falling edge. It holds the strap steady within each check, as a real strap would be. The random addresses span the whole 20-bit space with both strap settings and both lock-release levels. Directed passes add the first and last word of all 39 blocks in both layouts.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  // Default geometry of the array (word addressing).
  localparam int unsigned ADDR_W_DEF  = 20;
  localparam int unsigned SMALL_W_DEF = 12;  // 4K-word block
  localparam int unsigned LARGE_W_DEF = 15;  // 32K-word block
  localparam int unsigned N_SMALL_DEF = 8;
  localparam int unsigned N_BOOT_DEF  = 2;

  typedef enum logic {
    LAYOUT_BOTTOM = 1'b0,
    LAYOUT_TOP    = 1'b1
  } layout_e;
endpackage

// File: rtl/fbm_region.sv
// Finds whether the address lies in the small-block region and extracts the
// sub-block number inside that region and the raw large-block slot number.
module fbm_region
  import fbm_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned SMALL_W = SMALL_W_DEF,
  parameter int unsigned LARGE_W = LARGE_W_DEF,
  parameter int unsigned N_SMALL = N_SMALL_DEF,
  localparam int unsigned SUB_W  = $clog2(N_SMALL),
  localparam int unsigned SLOT_W = ADDR_W - LARGE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  layout_e           layout_i,
  output logic              in_small_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [ADDR_W:0] SPAN     = (ADDR_W+1)'(N_SMALL) << SMALL_W;
  localparam logic [ADDR_W:0] TOP_BASE = ((ADDR_W+1)'(1) << ADDR_W) - SPAN;

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] offset;

  always_comb begin
    addr_x = {1'b0, addr_i};
    if (layout_i == LAYOUT_TOP) begin
      in_small_o = (addr_x >= TOP_BASE);
      offset     = addr_x - TOP_BASE;
    end else begin
      in_small_o = (addr_x < SPAN);
      offset     = addr_x;
    end
    sub_o  = SUB_W'(offset >> SMALL_W);
    slot_o = SLOT_W'(addr_x >> LARGE_W);
  end

  // R1 R3: inside the small region the offset never exceeds the region span
  always_comb begin
    assert_region_span_R3: assert (!in_small_o || (offset < SPAN))
      else $error("small region offset out of span");
  end
endmodule

// File: rtl/fbm_indexer.sv
// Merges the small/large classification into one ascending block index.
module fbm_indexer
  import fbm_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned SMALL_W = SMALL_W_DEF,
  parameter int unsigned LARGE_W = LARGE_W_DEF,
  parameter int unsigned N_SMALL = N_SMALL_DEF,
  localparam int unsigned SUB_W   = $clog2(N_SMALL),
  localparam int unsigned SLOT_W  = ADDR_W - LARGE_W,
  localparam int unsigned SKIP    = (N_SMALL << SMALL_W) >> LARGE_W,
  localparam int unsigned N_LARGE = (1 << SLOT_W) - SKIP,
  localparam int unsigned N_BLK   = N_SMALL + N_LARGE,
  localparam int unsigned IDX_W   = $clog2(N_BLK)
) (
  input  layout_e           layout_i,
  input  logic              in_small_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] sub_x, slot_x;

  always_comb begin
    sub_x  = IDX_W'(sub_i);
    slot_x = IDX_W'(slot_i);
    if (layout_i == LAYOUT_TOP)
      idx_o = in_small_i ? IDX_W'(N_LARGE) + sub_x : slot_x;
    else
      idx_o = in_small_i ? sub_x : slot_x + IDX_W'(N_SMALL) - IDX_W'(SKIP);
  end

  // R8: the index never leaves the block count
  always_comb begin
    assert_idx_range_R8: assert (32'(idx_o) < N_BLK)
      else $error("block index %0d out of range", idx_o);
  end
  // R1 R3: small blocks land in the expected index band for each layout
  always_comb begin
    assert_small_band_R1: assert (!in_small_i ||
        ((layout_i == LAYOUT_TOP) ? (32'(idx_o) >= N_LARGE) : (32'(idx_o) < N_SMALL)))
      else $error("small block index %0d outside band", idx_o);
  end
endmodule

// File: rtl/fbm_guard.sv
// Flags the boot blocks and gates the write permit with the lock release.
module fbm_guard
  import fbm_pkg::*;
#(
  parameter int unsigned N_SMALL = N_SMALL_DEF,
  parameter int unsigned N_BOOT  = N_BOOT_DEF,
  localparam int unsigned SUB_W  = $clog2(N_SMALL)
) (
  input  layout_e          layout_i,
  input  logic             in_small_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic             unlock_i,
  output logic             boot_o,
  output logic             write_ok_o
);
  localparam logic [SUB_W-1:0] HI_FIRST = SUB_W'(N_SMALL - N_BOOT);
  localparam logic [SUB_W-1:0] LO_END   = SUB_W'(N_BOOT);

  logic outer;

  always_comb begin
    outer      = (layout_i == LAYOUT_TOP) ? (sub_i >= HI_FIRST) : (sub_i < LO_END);
    boot_o     = in_small_i && outer;
    write_ok_o = !boot_o || unlock_i;
  end

  // R6: a locked boot target is never permitted
  always_comb begin
    assert_locked_boot_R6: assert (!(boot_o && !unlock_i) || !write_ok_o)
      else $error("boot block permitted while locked");
  end
endmodule

// File: rtl/flash_block_map.sv
module flash_block_map
  import fbm_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned SMALL_W = SMALL_W_DEF,
  parameter int unsigned LARGE_W = LARGE_W_DEF,
  parameter int unsigned N_SMALL = N_SMALL_DEF,
  parameter int unsigned N_BOOT  = N_BOOT_DEF,
  localparam int unsigned SUB_W   = $clog2(N_SMALL),
  localparam int unsigned SLOT_W  = ADDR_W - LARGE_W,
  localparam int unsigned SKIP    = (N_SMALL << SMALL_W) >> LARGE_W,
  localparam int unsigned N_LARGE = (1 << SLOT_W) - SKIP,
  localparam int unsigned IDX_W   = $clog2(N_SMALL + N_LARGE)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              top_boot_i,
  input  logic              boot_unlock_i,
  output logic [IDX_W-1:0]  blk_idx_o,
  output logic              small_blk_o,
  output logic              boot_blk_o,
  output logic              write_ok_o
);
  layout_e           layout;
  logic [SUB_W-1:0]  sub;
  logic [SLOT_W-1:0] slot;

  assign layout = top_boot_i ? LAYOUT_TOP : LAYOUT_BOTTOM;

  fbm_region #(
    .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W), .N_SMALL(N_SMALL)
  ) u_region (
    .addr_i(addr_i), .layout_i(layout),
    .in_small_o(small_blk_o), .sub_o(sub), .slot_o(slot)
  );

  fbm_indexer #(
    .ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W), .N_SMALL(N_SMALL)
  ) u_index (
    .layout_i(layout), .in_small_i(small_blk_o), .sub_i(sub), .slot_i(slot),
    .idx_o(blk_idx_o)
  );

  fbm_guard #(
    .N_SMALL(N_SMALL), .N_BOOT(N_BOOT)
  ) u_guard (
    .layout_i(layout), .in_small_i(small_blk_o), .sub_i(sub),
    .unlock_i(boot_unlock_i), .boot_o(boot_blk_o), .write_ok_o(write_ok_o)
  );

  // R5: a boot block is always a small block
  always_comb begin
    assert_boot_is_small_R5: assert (!boot_blk_o || small_blk_o)
      else $error("boot flag without small flag");
  end
  // R7: outside the boot blocks the permit stays high
  always_comb begin
    assert_nonboot_open_R7: assert (boot_blk_o || write_ok_o)
      else $error("non-boot block refused");
  end
  // R5: boot blocks sit at the outer end of the address space
  always_comb begin
    assert_boot_end_R5: assert (!boot_blk_o ||
        (top_boot_i ? (addr_i[ADDR_W-1 -: 1] == 1'b1) : (addr_i[ADDR_W-1 -: 1] == 1'b0)))
      else $error("boot flag on wrong half of the array");
  end
endmodule

// File: tb/flash_block_map_test.sv
module flash_block_map_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr;
  logic        top_boot;
  logic        unlock;
  logic [5:0]  idx;
  logic        small_f, boot_f, wok;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  flash_block_map uut (
    .addr_i(addr), .top_boot_i(top_boot), .boot_unlock_i(unlock),
    .blk_idx_o(idx), .small_blk_o(small_f), .boot_blk_o(boot_f), .write_ok_o(wok)
  );

  // Expected decode taken from the requirements.
  function automatic void model(input logic [19:0] a, input logic top, input logic ul,
                                output int e_idx, output bit e_sm, output bit e_bt,
                                output bit e_ok, output string tag);
    if (top) begin
      if (a >= 20'hF8000) begin e_sm = 1; e_idx = 31 + int'(a[14:12]); tag = "R1"; end
      else begin e_sm = 0; e_idx = int'(a[19:15]); tag = "R2"; end
      e_bt = (e_idx >= 37);
    end else begin
      if (a < 20'h08000) begin e_sm = 1; e_idx = int'(a[14:12]); tag = "R3"; end
      else begin e_sm = 0; e_idx = int'(a[19:15]) + 7; tag = "R4"; end
      e_bt = (e_idx <= 1);
    end
    e_ok = !e_bt || ul;
  endfunction

  function automatic logic [19:0] blk_base(input int i, input logic top);
    if (top) return (i < 31) ? 20'(i << 15) : 20'hF8000 + 20'((i - 31) << 12);
    else     return (i < 8)  ? 20'(i << 12) : 20'((i - 7) << 15);
  endfunction

  function automatic logic [19:0] blk_last(input int i, input logic top);
    if (top) return blk_base(i, top) + ((i < 31) ? 20'h07FFF : 20'h00FFF);
    else     return blk_base(i, top) + ((i < 8)  ? 20'h00FFF : 20'h07FFF);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s addr=%05h top=%0b unlock=%0b actual=%0d expected=%0d",
               req, addr, top_boot, unlock, act, exp);
    end
  endtask

  task automatic apply(input logic [19:0] a, input logic top, input logic ul);
    @(posedge clk);
    addr = a; top_boot = top; unlock = ul;
    @(negedge clk);
  endtask

  task automatic full_check(input logic [19:0] a, input logic top, input logic ul);
    int e_idx; bit e_sm, e_bt, e_ok; string tag;
    apply(a, top, ul);
    model(a, top, ul, e_idx, e_sm, e_bt, e_ok, tag);
    check({tag, " index"}, int'(idx), e_idx);
    check({tag, " small"}, int'(small_f), int'(e_sm));
    check("R5 boot", int'(boot_f), int'(e_bt));
    check(e_bt ? "R6 permit" : "R7 permit", int'(wok), int'(e_ok));
  endtask

  initial begin
    int seed_v;
    addr = '0; top_boot = 1'b1; unlock = 1'b0;
    seed_v = $urandom(32'h5EED_0BB1);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state style check: address zero, top layout, locked
    @(negedge clk);
    check("R2 idx at 0", int'(idx), 0);
    check("R2 small at 0", int'(small_f), 0);
    check("R7 permit at 0", int'(wok), 1);

    // R8: first and last word of every block, both layouts, both lock levels
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < 39; b++) begin
        for (int u = 0; u < 2; u++) begin
          full_check(blk_base(b, t[0]), t[0], u[0]);
          check("R8 first word", int'(idx), b);
          full_check(blk_last(b, t[0]), t[0], u[0]);
          check("R8 last word", int'(idx), b);
        end
      end
    end

    // R6: boot corners explicitly
    full_check(20'hFFFFF, 1'b1, 1'b0); check("R6 top boot locked", int'(wok), 0);
    full_check(20'hFE000, 1'b1, 1'b1); check("R6 top boot open", int'(wok), 1);
    full_check(20'hFDFFF, 1'b1, 1'b0); check("R5 top below boot", int'(boot_f), 0);
    full_check(20'h00000, 1'b0, 1'b0); check("R6 bottom boot locked", int'(wok), 0);
    full_check(20'h01FFF, 1'b0, 1'b0); check("R5 bottom boot edge", int'(boot_f), 1);
    full_check(20'h02000, 1'b0, 1'b0); check("R5 bottom above boot", int'(boot_f), 0);

    // R7: lock release leaves non-boot decode and permit unchanged
    for (int k = 0; k < 200; k++) begin
      logic [19:0] a; logic t; int i0; bit s0, b0;
      a = 20'($urandom); t = 1'($urandom);
      apply(a, t, 1'b0); i0 = int'(idx); s0 = small_f; b0 = boot_f;
      if (!b0) check("R7 locked permit", int'(wok), 1);
      apply(a, t, 1'b1);
      check("R7 idx unchanged", int'(idx), i0);
      check("R7 small unchanged", int'(small_f), int'(s0));
      check("R7 boot unchanged", int'(boot_f), int'(b0));
    end

    // Random sweep, biased toward the small region half the time
    for (int k = 0; k < 3000; k++) begin
      logic [19:0] a; logic t;
      t = 1'($urandom);
      a = 20'($urandom);
      if ($urandom % 2 == 0) a = t ? {5'b11111, a[14:0]} : {5'b00000, a[14:0]};
      full_check(a, t, 1'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule